// File: doc/BRIEF.md
# Serial Configuration Port with Four Routed Holding Latches

This block receives configuration words for a two-channel frequency synthesizer over a three-wire serial link: a serial clock, a data line and a load strobe. All three wires are brought into the fast system clock through synchronizers. Each detected rise of the serial clock shifts one data bit into a 22-bit shift register. A detected rise of the load strobe copies the shifted word into one of four holding latches. The two bits received last pick the latch: a reference-divider latch or a feedback-divider latch, for either channel. Each latch has its own field layout. All latched fields are driven out in parallel to the divider and charge-pump logic.

A small load controller handles each strobe and passes through four named states. ST_IDLE waits for the strobe and takes a snapshot of the shift register when the strobe rises. ST_IDLE goes to ST_CHECK, which validates the snapshot (reference ratio at least 3; main count at least 3 and greater than the swallow count). ST_CHECK always goes to ST_COMMIT. ST_COMMIT writes the addressed latch, or raises the sticky error flag for a rejected word, and always goes to ST_HOLD. ST_HOLD waits for the strobe to fall and then returns to ST_IDLE.

After reset every latch is zero, except that both charge-pump tri-state bits are set. The charge pumps therefore stay quiet until the port has been programmed.

Top module: `ser_cfg_port`

## Requirements
- R1: Each synchronized rising edge of `ser_clk` shifts the synchronized `ser_data` into the shift register. The word is sent most significant bit first, so the last bit received is bit position 1 (the LSB).
- R2: Position 1 is address bit A0 and position 2 is address bit A1. {A0,A1}: 00 selects the channel-2 reference latch, 01 the channel-1 reference latch, 10 the channel-2 divider latch, 11 the channel-1 divider latch.
- R3: In a reference word, positions 3..17 carry the 15-bit reference ratio (position 3 is its LSB). Position 18 is phase-detector polarity, 19 is charge-pump boost, 20 is charge-pump tri-state, 21 is monitor select A and 22 is monitor select B.
- R4: In a divider word, positions 3..9 carry the 7-bit swallow count (position 3 is its LSB), positions 10..20 carry the 11-bit main count (position 10 is its LSB), position 21 is the prescaler modulus select and position 22 is the power-save bit.
- R5: A single rising edge of `ser_le` updates exactly one latch. The other three latches keep their contents.
- R6: A reference word whose ratio is below 3 is rejected: the addressed latch is unchanged and `cfg_err` is set.
- R7: A divider word whose main count is below 3, or whose swallow count is greater than or equal to the main count, is rejected: the latch is unchanged and `cfg_err` is set.
- R8: `cfg_err` stays high until reset, including across later accepted words.
- R9: After reset all latched outputs are zero, except `ch1_cp_hiz` and `ch2_cp_hiz`, which are 1. `cfg_err` is 0.
- R10: If more than 22 bits arrive before the strobe, only the last 22 bits form the word.
- R11: A channel whose latched power-save bit is 1 still accepts and applies new words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data (asynchronous) |
| ser_le | input | 1 | Load strobe (asynchronous) |
| ch1_ref_div | output | 15 | Channel-1 reference ratio |
| ch1_pd_invert | output | 1 | Channel-1 phase-detector polarity |
| ch1_cp_boost | output | 1 | Channel-1 charge-pump boost |
| ch1_cp_hiz | output | 1 | Channel-1 charge-pump tri-state |
| ch1_mon_sel_a | output | 1 | Channel-1 monitor select A |
| ch1_mon_sel_b | output | 1 | Channel-1 monitor select B |
| ch2_ref_div | output | 15 | Channel-2 reference ratio |
| ch2_pd_invert | output | 1 | Channel-2 phase-detector polarity |
| ch2_cp_boost | output | 1 | Channel-2 charge-pump boost |
| ch2_cp_hiz | output | 1 | Channel-2 charge-pump tri-state |
| ch2_mon_sel_a | output | 1 | Channel-2 monitor select A |
| ch2_mon_sel_b | output | 1 | Channel-2 monitor select B |
| ch1_swallow | output | 7 | Channel-1 swallow count |
| ch1_main_div | output | 11 | Channel-1 main count |
| ch1_pre_big | output | 1 | Channel-1 prescaler modulus select |
| ch1_pwr_save | output | 1 | Channel-1 power-save |
| ch2_swallow | output | 7 | Channel-2 swallow count |
| ch2_main_div | output | 11 | Channel-2 main count |
| ch2_pre_big | output | 1 | Channel-2 prescaler modulus select |
| ch2_pwr_save | output | 1 | Channel-2 power-save |
| cfg_err | output | 1 | Sticky rejected-word flag |

## Verification
The bench sends one word to each of the four addresses, each with a distinct ratio and mode pattern. A swapped address bit or a field shifted by one position therefore shows up as a wrong value in a latch that should have been left alone. Ratios of exactly 3 and a swallow count of 127 against a main count of 2047 probe the acceptance bounds from the legal side. A ratio of 2, a main count of 2, and a swallow count equal to the main count probe them from the illegal side, and the bench confirms that the latch contents survive each rejection. A 25-bit word with leading junk bits shows whether the oldest bits fall out of the register. Words sent to a channel that is already in power-save show that loading does not depend on that bit.

// File: rtl/sercfg_pkg.sv
`timescale 1ns/1ps
package sercfg_pkg;

    localparam int WORD_W    = 22;
    localparam int R_W       = 15;
    localparam int A_W       = 7;
    localparam int N_W       = 11;
    localparam int NUM_CH    = 2;
    localparam int MIN_RATIO = 3;
    localparam int ADDR_W    = 2;

    localparam int R_LSB  = ADDR_W;
    localparam int MD_LSB = R_LSB + R_W;
    localparam int A_LSB  = ADDR_W;
    localparam int N_LSB  = A_LSB + A_W;
    localparam int SW_POS = N_LSB + N_W;
    localparam int PS_POS = SW_POS + 1;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic           mon_b;
        logic           mon_a;
        logic           cp_hiz;
        logic           cp_boost;
        logic           pd_invert;
        logic [R_W-1:0] ratio;
    } ref_cfg_t;

    typedef struct packed {
        logic           pwr_save;
        logic           pre_big;
        logic [N_W-1:0] main_cnt;
        logic [A_W-1:0] swallow;
    } div_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CHECK  = 2'd1,
        ST_COMMIT = 2'd2,
        ST_HOLD   = 2'd3
    } load_state_t;

    // index is {A0, A1}: A0 = last bit received
    typedef enum logic [1:0] {
        DST_REF_CH2 = 2'b00,
        DST_REF_CH1 = 2'b01,
        DST_DIV_CH2 = 2'b10,
        DST_DIV_CH1 = 2'b11
    } dest_t;

    localparam ref_cfg_t REF_RESET = '{mon_b: 1'b0, mon_a: 1'b0, cp_hiz: 1'b1,
                                      cp_boost: 1'b0, pd_invert: 1'b0, ratio: '0};
    localparam div_cfg_t DIV_RESET = '0;

    function automatic ref_cfg_t word_to_ref(input word_t w);
        ref_cfg_t r;
        r.ratio     = w[R_LSB +: R_W];
        r.pd_invert = w[MD_LSB];
        r.cp_boost  = w[MD_LSB + 1];
        r.cp_hiz    = w[MD_LSB + 2];
        r.mon_a     = w[MD_LSB + 3];
        r.mon_b     = w[MD_LSB + 4];
        return r;
    endfunction

    function automatic div_cfg_t word_to_div(input word_t w);
        div_cfg_t d;
        d.swallow  = w[A_LSB +: A_W];
        d.main_cnt = w[N_LSB +: N_W];
        d.pre_big  = w[SW_POS];
        d.pwr_save = w[PS_POS];
        return d;
    endfunction

    function automatic dest_t word_dest(input word_t w);
        return dest_t'({w[0], w[1]});
    endfunction

endpackage

// File: rtl/sercfg_sync.sv
`timescale 1ns/1ps
module sercfg_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [STAGES-1:0][W-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= {stage_q[STAGES-2:0], async_i};
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/sercfg_shifter.sv
`timescale 1ns/1ps
module sercfg_shifter #(
    parameter int W = sercfg_pkg::WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] word_o
);
    logic [W-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (shift_en) begin
            sr_q <= {sr_q[W-2:0], din};
        end
    end

    assign word_o = sr_q;

    // R1: newest bit lands at position 1
    a_r1_newest_at_lsb: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (word_o[0] == $past(din)));

    // R10: older bits move one position toward the MSB, oldest falls out
    a_r10_older_move_up: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (word_o[W-1:1] == $past(word_o[W-2:0])));

endmodule

// File: rtl/sercfg_load_fsm.sv
`timescale 1ns/1ps
module sercfg_load_fsm
    import sercfg_pkg::*;
#(
    parameter int CH = NUM_CH
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          le_rise,
    input  logic          le_lvl,
    input  word_t         shift_word,
    output word_t         snap_o,
    output logic [CH-1:0] wr_ref,
    output logic [CH-1:0] wr_div,
    output logic          err_set
);
    load_state_t state_q, state_d;
    word_t       snap_q;
    logic        ok_q;
    logic        word_ok;
    ref_cfg_t    chk_ref;
    div_cfg_t    chk_div;

    // validity of the captured word
    always_comb begin
        chk_ref = word_to_ref(snap_q);
        chk_div = word_to_div(snap_q);
        if (snap_q[0]) begin
            word_ok = (chk_div.main_cnt >= N_W'(MIN_RATIO)) &&
                      (N_W'(chk_div.swallow) < chk_div.main_cnt);
        end else begin
            word_ok = (chk_ref.ratio >= R_W'(MIN_RATIO));
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath registers owned by the controller
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q <= '0;
            ok_q   <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && le_rise) begin
                snap_q <= shift_word;
            end
            if (state_q == ST_CHECK) begin
                ok_q <= word_ok;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (le_rise) state_d = ST_CHECK;
            ST_CHECK:  state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_HOLD;
            ST_HOLD:   if (!le_lvl) state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        wr_ref  = '0;
        wr_div  = '0;
        err_set = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_CHECK, ST_HOLD: begin
            end
            ST_COMMIT: begin
                if (ok_q) begin
                    unique case (word_dest(snap_q))
                        DST_REF_CH1: wr_ref[0] = 1'b1;
                        DST_REF_CH2: wr_ref[1] = 1'b1;
                        DST_DIV_CH1: wr_div[0] = 1'b1;
                        DST_DIV_CH2: wr_div[1] = 1'b1;
                    endcase
                end else begin
                    err_set = 1'b1;
                end
            end
        endcase
    end

    assign snap_o = snap_q;

    // R5: a strobe is always followed by exactly one commit slot
    a_r5_check_then_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHECK) |=> (state_q == ST_COMMIT));

    // R5: never more than one latch written at a time
    a_r5_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_ref, wr_div}));

    // R5: a new word is only taken from idle
    a_r5_snap_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(snap_q));

    // R6 / R7: a rejected word writes nothing
    a_r6_reject_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        err_set |-> ({wr_ref, wr_div} == '0));

endmodule

// File: rtl/sercfg_latch_bank.sv
`timescale 1ns/1ps
module sercfg_latch_bank
    import sercfg_pkg::*;
#(
    parameter int CH = NUM_CH
) (
    input  logic          clk,
    input  logic          rst_n,
    input  word_t         word_i,
    input  logic [CH-1:0] wr_ref,
    input  logic [CH-1:0] wr_div,
    output ref_cfg_t      ref_o [CH],
    output div_cfg_t      div_o [CH]
);
    ref_cfg_t new_ref;
    div_cfg_t new_div;

    assign new_ref = word_to_ref(word_i);
    assign new_div = word_to_div(word_i);

    for (genvar g = 0; g < CH; g++) begin : g_chan
        ref_cfg_t ref_q;
        div_cfg_t div_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ref_q <= REF_RESET;
            end else if (wr_ref[g]) begin
                ref_q <= new_ref;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                div_q <= DIV_RESET;
            end else if (wr_div[g]) begin
                div_q <= new_div;
            end
        end

        assign ref_o[g] = ref_q;
        assign div_o[g] = div_q;
    end

endmodule

// File: rtl/ser_cfg_port.sv
`timescale 1ns/1ps
module ser_cfg_port
    import sercfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ser_clk,
    input  logic           ser_data,
    input  logic           ser_le,
    output logic [R_W-1:0] ch1_ref_div,
    output logic           ch1_pd_invert,
    output logic           ch1_cp_boost,
    output logic           ch1_cp_hiz,
    output logic           ch1_mon_sel_a,
    output logic           ch1_mon_sel_b,
    output logic [R_W-1:0] ch2_ref_div,
    output logic           ch2_pd_invert,
    output logic           ch2_cp_boost,
    output logic           ch2_cp_hiz,
    output logic           ch2_mon_sel_a,
    output logic           ch2_mon_sel_b,
    output logic [A_W-1:0] ch1_swallow,
    output logic [N_W-1:0] ch1_main_div,
    output logic           ch1_pre_big,
    output logic           ch1_pwr_save,
    output logic [A_W-1:0] ch2_swallow,
    output logic [N_W-1:0] ch2_main_div,
    output logic           ch2_pre_big,
    output logic           ch2_pwr_save,
    output logic           cfg_err
);
    localparam int PIN_N = 3;

    logic [PIN_N-1:0] pins_s;
    logic             sclk_s, sdat_s, le_s;
    logic             sclk_d, le_d;
    logic             sclk_rise, le_rise;
    word_t            shift_word, snap_word;
    logic [NUM_CH-1:0] wr_ref, wr_div;
    logic             err_set;
    logic             err_q;
    ref_cfg_t         ref_cfg [NUM_CH];
    div_cfg_t         div_cfg [NUM_CH];

    sercfg_sync #(.W(PIN_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_le, ser_data, ser_clk}),
        .sync_o  (pins_s)
    );

    assign sclk_s = pins_s[0];
    assign sdat_s = pins_s[1];
    assign le_s   = pins_s[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            le_d   <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
            le_d   <= le_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_d;
    assign le_rise   = le_s & ~le_d;

    sercfg_shifter #(.W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (sclk_rise),
        .din      (sdat_s),
        .word_o   (shift_word)
    );

    sercfg_load_fsm #(.CH(NUM_CH)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .le_rise    (le_rise),
        .le_lvl     (le_s),
        .shift_word (shift_word),
        .snap_o     (snap_word),
        .wr_ref     (wr_ref),
        .wr_div     (wr_div),
        .err_set    (err_set)
    );

    sercfg_latch_bank #(.CH(NUM_CH)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .word_i (snap_word),
        .wr_ref (wr_ref),
        .wr_div (wr_div),
        .ref_o  (ref_cfg),
        .div_o  (div_cfg)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (err_set) begin
            err_q <= 1'b1;
        end
    end

    assign cfg_err = err_q;

    assign ch1_ref_div   = ref_cfg[0].ratio;
    assign ch1_pd_invert = ref_cfg[0].pd_invert;
    assign ch1_cp_boost  = ref_cfg[0].cp_boost;
    assign ch1_cp_hiz    = ref_cfg[0].cp_hiz;
    assign ch1_mon_sel_a = ref_cfg[0].mon_a;
    assign ch1_mon_sel_b = ref_cfg[0].mon_b;
    assign ch2_ref_div   = ref_cfg[1].ratio;
    assign ch2_pd_invert = ref_cfg[1].pd_invert;
    assign ch2_cp_boost  = ref_cfg[1].cp_boost;
    assign ch2_cp_hiz    = ref_cfg[1].cp_hiz;
    assign ch2_mon_sel_a = ref_cfg[1].mon_a;
    assign ch2_mon_sel_b = ref_cfg[1].mon_b;
    assign ch1_swallow   = div_cfg[0].swallow;
    assign ch1_main_div  = div_cfg[0].main_cnt;
    assign ch1_pre_big   = div_cfg[0].pre_big;
    assign ch1_pwr_save  = div_cfg[0].pwr_save;
    assign ch2_swallow   = div_cfg[1].swallow;
    assign ch2_main_div  = div_cfg[1].main_cnt;
    assign ch2_pre_big   = div_cfg[1].pre_big;
    assign ch2_pwr_save  = div_cfg[1].pwr_save;

    // R6: a latched reference ratio is either the reset value or legal
    a_r6_ref_ratio_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (ch1_ref_div == '0 || ch1_ref_div >= R_W'(MIN_RATIO)) &&
        (ch2_ref_div == '0 || ch2_ref_div >= R_W'(MIN_RATIO)));

    // R7: a latched divider pair is either the reset value or legal
    a_r7_div_pair_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (ch1_main_div == '0 ||
         (ch1_main_div >= N_W'(MIN_RATIO) && N_W'(ch1_swallow) < ch1_main_div)) &&
        (ch2_main_div == '0 ||
         (ch2_main_div >= N_W'(MIN_RATIO) && N_W'(ch2_swallow) < ch2_main_div)));

    // R8: the error flag never falls while out of reset
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    // R5: latch outputs move only after a strobe has been seen
    a_r5_no_change_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_ref == '0) && (wr_div == '0)) |=>
            ($stable(ch1_ref_div) && $stable(ch2_ref_div) &&
             $stable(ch1_main_div) && $stable(ch2_main_div)));

endmodule

// File: tb/tb_ser_cfg_port.sv
`timescale 1ns/1ps
module tb_ser_cfg_port;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;

    logic [14:0] ch1_ref_div, ch2_ref_div;
    logic ch1_pd_invert, ch1_cp_boost, ch1_cp_hiz, ch1_mon_sel_a, ch1_mon_sel_b;
    logic ch2_pd_invert, ch2_cp_boost, ch2_cp_hiz, ch2_mon_sel_a, ch2_mon_sel_b;
    logic [6:0]  ch1_swallow, ch2_swallow;
    logic [10:0] ch1_main_div, ch2_main_div;
    logic ch1_pre_big, ch1_pwr_save, ch2_pre_big, ch2_pwr_save, cfg_err;

    always #2.5 clk = ~clk;

    ser_cfg_port dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
        .ch1_ref_div(ch1_ref_div), .ch1_pd_invert(ch1_pd_invert), .ch1_cp_boost(ch1_cp_boost),
        .ch1_cp_hiz(ch1_cp_hiz), .ch1_mon_sel_a(ch1_mon_sel_a), .ch1_mon_sel_b(ch1_mon_sel_b),
        .ch2_ref_div(ch2_ref_div), .ch2_pd_invert(ch2_pd_invert), .ch2_cp_boost(ch2_cp_boost),
        .ch2_cp_hiz(ch2_cp_hiz), .ch2_mon_sel_a(ch2_mon_sel_a), .ch2_mon_sel_b(ch2_mon_sel_b),
        .ch1_swallow(ch1_swallow), .ch1_main_div(ch1_main_div), .ch1_pre_big(ch1_pre_big),
        .ch1_pwr_save(ch1_pwr_save), .ch2_swallow(ch2_swallow), .ch2_main_div(ch2_main_div),
        .ch2_pre_big(ch2_pre_big), .ch2_pwr_save(ch2_pwr_save), .cfg_err(cfg_err)
    );

    // expected state: index 0 = channel 1, index 1 = channel 2
    typedef struct packed {
        logic [1:0][14:0] r;
        logic [1:0][4:0]  m;   // {polarity, boost, tri-state, mon A, mon B}
        logic [1:0][6:0]  a;
        logic [1:0][10:0] n;
        logic [1:0][1:0]  sp;  // {modulus select, power-save}
        logic             err;
    } exp_t;

    exp_t  model;
    exp_t  exp_q[$];
    string tag_q[$];
    event  item_ev;
    int    checks = 0;
    int    failures = 0;
    bit    finished = 1'b0;

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic push_expect(input string tag);
        exp_q.push_back(model);
        tag_q.push_back(tag);
        -> item_ev;
    endtask

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(item_ev);
            while (exp_q.size() != 0) begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, "ch1 ratio", int'(ch1_ref_div), int'(e.r[0]));
                check(t, "ch2 ratio", int'(ch2_ref_div), int'(e.r[1]));
                check(t, "ch1 modes", int'({ch1_pd_invert, ch1_cp_boost, ch1_cp_hiz,
                                            ch1_mon_sel_a, ch1_mon_sel_b}), int'(e.m[0]));
                check(t, "ch2 modes", int'({ch2_pd_invert, ch2_cp_boost, ch2_cp_hiz,
                                            ch2_mon_sel_a, ch2_mon_sel_b}), int'(e.m[1]));
                check(t, "ch1 swallow", int'(ch1_swallow), int'(e.a[0]));
                check(t, "ch2 swallow", int'(ch2_swallow), int'(e.a[1]));
                check(t, "ch1 main", int'(ch1_main_div), int'(e.n[0]));
                check(t, "ch2 main", int'(ch2_main_div), int'(e.n[1]));
                check(t, "ch1 sw/ps", int'({ch1_pre_big, ch1_pwr_save}), int'(e.sp[0]));
                check(t, "ch2 sw/ps", int'({ch2_pre_big, ch2_pwr_save}), int'(e.sp[1]));
                check(t, "cfg_err", int'(cfg_err), int'(e.err));
            end
        end
    end

    // driver: MSB first, then strobe (R1)
    task automatic send_bits(input logic [31:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk);
            ser_data = bits[i];
            repeat (3) @(negedge clk);
            ser_clk = 1'b1;
            repeat (4) @(negedge clk);
            ser_clk = 1'b0;
        end
        repeat (3) @(negedge clk);
        ser_le = 1'b1;
        repeat (6) @(negedge clk);
        ser_le = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    // R2/R3: reference word {B, A, tri, boost, pol, ratio, A1, A0}
    task automatic prog_ref(input int ch, input logic [14:0] r, input logic [4:0] m,
                            input string tag);
        logic [21:0] w;
        logic a1;
        a1 = (ch == 0);
        w = {m[0], m[1], m[2], m[3], m[4], r, a1, 1'b0};
        send_bits({10'b0, w}, 22);
        if (r >= 3) begin
            model.r[ch] = r;
            model.m[ch] = m;
        end else begin
            model.err = 1'b1;
        end
        push_expect(tag);
    endtask

    // R2/R4: divider word {ps, sw, N, A, A1, A0}
    task automatic prog_div(input int ch, input logic [6:0] a, input logic [10:0] n,
                            input logic sw, input logic ps, input int extra,
                            input string tag);
        logic [21:0] w;
        logic a1;
        a1 = (ch == 0);
        w = {ps, sw, n, a, a1, 1'b1};
        if (extra > 0) send_bits({7'b0, 3'b101, w}, 22 + extra);
        else           send_bits({10'b0, w}, 22);
        if (n >= 3 && {4'b0, a} < n) begin
            model.a[ch]  = a;
            model.n[ch]  = n;
            model.sp[ch] = {sw, ps};
        end else begin
            model.err = 1'b1;
        end
        push_expect(tag);
    endtask

    initial begin
        model = '0;
        model.m[0] = 5'b00100;
        model.m[1] = 5'b00100;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        push_expect("R9 reset");

        prog_ref(0, 15'd1000, 5'b10010, "R1 R2 R3 ch1 ref");
        prog_ref(1, 15'd3,    5'b01101, "R2 R3 ch2 ref min");
        prog_div(0, 7'd5,   11'd100,  1'b1, 1'b0, 0, "R2 R4 R5 ch1 div");
        prog_div(1, 7'd127, 11'd2047, 1'b0, 1'b1, 0, "R2 R4 R5 ch2 div max");
        prog_ref(0, 15'd32767, 5'b11111, "R3 ch1 ref all ones");
        prog_div(0, 7'd1, 11'd3, 1'b1, 1'b1, 3, "R10 long word");
        prog_div(0, 7'd2, 11'd9, 1'b0, 1'b1, 0, "R11 load in power-save");
        prog_ref(1, 15'd2, 5'b10000, "R6 ratio below 3");
        prog_div(1, 7'd0, 11'd2, 1'b1, 1'b0, 0, "R7 main below 3");
        prog_div(0, 7'd100, 11'd100, 1'b0, 1'b0, 0, "R7 swallow equals main");
        prog_ref(1, 15'd12345, 5'b00001, "R8 sticky after accept");
        prog_div(1, 7'd10, 11'd11, 1'b1, 1'b0, 0, "R8 R5 sticky ch2 div");

        repeat (10) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            failures++;
            $display("FAIL watchdog run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule